// File: doc/BRIEF.md
# SPI Controller Register and Status Block

This block is the host-side register file of an SPI controller. A simple peripheral bus (select, strobe, write, 14-bit byte address, 32-bit data) reaches the control, mode, receive-data, transmit-data, status, interrupt-set, interrupt-clear, interrupt-mask and four chip-select configuration registers. The block keeps the flags that describe the data path: receive buffer full, transmit buffer empty, overrun, mode fault and enabled. It drives one level interrupt from those flags and the mask.

On the data side it talks to a separate serializer. It offers a transmit word and its chip-select code. It pulses `ser_load` when the serializer takes the word. It accepts a received word with the chip-select value seen at the end of the transfer when `ser_done` pulses. A synchronized slave-select input is watched for a mode fault while the controller is enabled as a master.

Reads have side effects. Reading status clears the overrun and mode-fault flags. Reading receive data clears the receive-full flag. Mode and chip-select settings are exported as plain configuration buses.

Top module: `spi_regfile`

## Requirements
- R1: Registers sit at word offsets: control 0x00, mode 0x04, receive data 0x08, transmit data 0x0C, status 0x10, mask set 0x14, mask clear 0x18, mask 0x1C, chip-select configs 0x30/0x34/0x38/0x3C. Address bits [1:0] are ignored. Unmapped addresses, write-only registers and undefined bits read 0. After reset every readable register reads 0.
- R2: In a control write, bit0 enables and bit1 disables, and with both set the controller is disabled. Status bit16 reads 1 while enabled.
- R3: A disable written while `ser_busy` is high keeps the controller enabled until the first clock with `ser_busy` low, then disables it.
- R4: Status bit1 (transmit empty) is 0 at reset and while disabled. Enabling a disabled controller sets it. A transmit-data write clears it and stores data [15:0] and chip-select code [19:16]. While enabled with the flag 0 and `ser_ready` high, `ser_load` is high with that data on `ser_tx_data`/`ser_tx_pcs`, and the flag is 1 on the next cycle.
- R5: A `ser_done` pulse sets status bit0 and loads receive data: [15:0] holds the word, and [19:16] holds `ser_rx_pcs` when mode bit0 (master) is 1, else 0. Reading receive data clears bit0.
- R6: A `ser_done` while bit0 is already set and receive data is not read in that cycle sets status bit3 (overrun). A status read clears it.
- R7: While enabled with mode bit0 = 1 and mode bit4 = 0, a low `ss_n` (after a SYNC_STAGES-flop synchronizer) sets status bit2 and disables the controller. A status read clears bit2. With mode bit4 = 1, a low `ss_n` has no effect.
- R8: Mask bits are bit0 receive full, bit1 transmit empty, bit2 mode fault and bit3 overrun. A 1 written to the set register sets the mask bit and a 1 written to the clear register clears it. Zeros change nothing.
- R9: `irq` is high exactly when some status bit [3:0] and its mask bit are both 1.
- R10: Mode keeps only bits 0-4, 7, 19:16 and 31:24 (mask 0xFF0F009F). Chip-select configs keep all bits except 3:2 (mask 0xFFFFFFF3). Both read back and drive `cfg_mode`/`cfg_cs`.
- R11: A control write with bit7 set returns every register, flag and mask to its reset value.
- R12: A status read in the same cycle as an event that sets overrun leaves overrun set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Block select |
| bus_stb | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 14 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the strobe cycle |
| irq | output | 1 | Level interrupt |
| ss_n | input | 1 | Slave-select pad input, active low |
| ser_ready | input | 1 | Serializer can accept a transmit word |
| ser_busy | input | 1 | Serializer transfer in progress |
| ser_load | output | 1 | Transmit word handed over this cycle |
| ser_tx_data | output | 16 | Transmit word |
| ser_tx_pcs | output | 4 | Chip-select code of the transmit word |
| ser_done | input | 1 | Received word valid, one-cycle pulse |
| ser_rx_data | input | 16 | Received word |
| ser_rx_pcs | input | 4 | Chip-select lines at end of transfer |
| ctl_enabled | output | 1 | Controller enabled |
| cfg_mode | output | 32 | Mode register contents |
| cfg_cs | output | 128 | Four chip-select configs, config 0 in the low word |

## Verification
Assertions watch the cycle-level rules on every clock: disable-over-enable priority, the hold of a disable while the serializer is busy, the transmit flag staying low while disabled and rising after a hand-over, receive-full and overrun setting after a completion, a mode fault leaving the controller off, and the interrupt following flags and mask. The read-side effects only show up in the bench's scenarios. These are flags clearing on status or data reads, a read racing an overrun event, the field layout of the receive word in master and slave mode, register masks, address aliasing and software reset. The bench also runs long random mixes of mask updates, completions and reads against a reference model.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;

    // control register bits
    localparam int unsigned CR_EN  = 0;
    localparam int unsigned CR_DIS = 1;
    localparam int unsigned CR_RST = 7;

    // mode register bits
    localparam int unsigned MR_MSTR    = 0;
    localparam int unsigned MR_MODFDIS = 4;

    // status / mask bit positions
    localparam int unsigned ST_RXF = 0;
    localparam int unsigned ST_TXE = 1;
    localparam int unsigned ST_MDF = 2;
    localparam int unsigned ST_OVR = 3;
    localparam int unsigned ST_ENA = 16;
    localparam int unsigned N_FLAGS = 4;

    // writable-bit masks
    localparam logic [31:0] MR_KEEP  = 32'hFF0F_009F;
    localparam logic [31:0] CSR_KEEP = 32'hFFFF_FFF3;

    // word indices of the registers
    localparam int unsigned IX_CR  = 0;
    localparam int unsigned IX_MR  = 1;
    localparam int unsigned IX_RDR = 2;
    localparam int unsigned IX_TDR = 3;
    localparam int unsigned IX_SR  = 4;
    localparam int unsigned IX_IER = 5;
    localparam int unsigned IX_IDR = 6;
    localparam int unsigned IX_IMR = 7;
    localparam int unsigned IX_CS0 = 12;

    typedef struct packed {
        logic cr;
        logic mr;
        logic rdr;
        logic tdr;
        logic sr;
        logic ier;
        logic idr;
        logic imr;
    } reg_hit_t;

endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/spi_rf_decode.sv
module spi_rf_decode
    import spi_rf_pkg::*;
#(
    parameter int unsigned IDX_W  = 12,
    parameter int unsigned NUM_CS = 4
) (
    input  logic [IDX_W-1:0]  idx,
    output reg_hit_t          hit,
    output logic [NUM_CS-1:0] cs_hit
);
    always_comb begin
        hit     = '0;
        hit.cr  = (idx == IDX_W'(IX_CR));
        hit.mr  = (idx == IDX_W'(IX_MR));
        hit.rdr = (idx == IDX_W'(IX_RDR));
        hit.tdr = (idx == IDX_W'(IX_TDR));
        hit.sr  = (idx == IDX_W'(IX_SR));
        hit.ier = (idx == IDX_W'(IX_IER));
        hit.idr = (idx == IDX_W'(IX_IDR));
        hit.imr = (idx == IDX_W'(IX_IMR));
    end

    generate
        for (genvar k = 0; k < NUM_CS; k++) begin : g_cs
            assign cs_hit[k] = (idx == IDX_W'(IX_CS0 + k));
        end
    endgenerate
endmodule

// File: rtl/spi_rf_irq.sv
module spi_rf_irq #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         swrst,
    input  logic         set_wr,
    input  logic         clr_wr,
    input  logic [N-1:0] wbits,
    input  logic [N-1:0] flags,
    output logic [N-1:0] mask,
    output logic         irq
);
    logic [N-1:0] mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (set_wr) mask_d = mask_d | wbits;
        if (clr_wr) mask_d = mask_d & ~wbits;
        if (swrst)  mask_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign mask = mask_q;
    assign irq  = |(flags & mask_q);
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
    import spi_rf_pkg::*;
#(
    parameter int unsigned ADDR_W      = 14,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned PCS_W       = 4,
    parameter int unsigned NUM_CS      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel,
    input  logic                     bus_stb,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic                     irq,
    input  logic                     ss_n,
    input  logic                     ser_ready,
    input  logic                     ser_busy,
    output logic                     ser_load,
    output logic [WORD_W-1:0]        ser_tx_data,
    output logic [PCS_W-1:0]         ser_tx_pcs,
    input  logic                     ser_done,
    input  logic [WORD_W-1:0]        ser_rx_data,
    input  logic [PCS_W-1:0]         ser_rx_pcs,
    output logic                     ctl_enabled,
    output logic [DATA_W-1:0]        cfg_mode,
    output logic [NUM_CS*DATA_W-1:0] cfg_cs
);
    localparam int unsigned IDX_W   = ADDR_W - 2;
    localparam int unsigned PCS_LSB = 16;

    typedef struct packed {
        logic              en;
        logic              pend_dis;
        logic              tdre;
        logic              rdrf;
        logic              ovres;
        logic              modf;
        logic [DATA_W-1:0] mr;
        logic [WORD_W-1:0] tdr_data;
        logic [PCS_W-1:0]  tdr_pcs;
        logic [WORD_W-1:0] rdr_data;
        logic [PCS_W-1:0]  rdr_pcs;
    } core_t;

    core_t st_d, st_q;
    logic [NUM_CS-1:0][DATA_W-1:0] csr_d, csr_q;

    reg_hit_t          hit;
    logic [NUM_CS-1:0] cs_hit;
    logic              acc, wr_acc, rd_acc;
    logic              cr_wr, tdr_wr, rdr_rd, sr_rd, swrst;
    logic              ss_sync_n, modf_evt;
    logic [N_FLAGS-1:0] flags, imr;

    spi_rf_decode #(.IDX_W(IDX_W), .NUM_CS(NUM_CS)) i_dec (
        .idx    (bus_addr[ADDR_W-1:2]),
        .hit    (hit),
        .cs_hit (cs_hit)
    );

    spi_rf_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_ss_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ss_n),
        .dout (ss_sync_n)
    );

    assign acc    = bus_sel & bus_stb;
    assign wr_acc = acc & bus_wr;
    assign rd_acc = acc & ~bus_wr;
    assign cr_wr  = wr_acc & hit.cr;
    assign tdr_wr = wr_acc & hit.tdr;
    assign rdr_rd = rd_acc & hit.rdr;
    assign sr_rd  = rd_acc & hit.sr;
    assign swrst  = cr_wr & bus_wdata[CR_RST];

    assign modf_evt = st_q.en & st_q.mr[MR_MSTR] & ~st_q.mr[MR_MODFDIS] & ~ss_sync_n;
    assign ser_load = st_q.en & ~st_q.tdre & ser_ready;

    always_comb begin
        st_d  = st_q;
        csr_d = csr_q;

        // a disable held back by a busy serializer completes here
        if (st_q.pend_dis && !ser_busy) begin
            st_d.en       = 1'b0;
            st_d.pend_dis = 1'b0;
        end

        if (cr_wr) begin
            if (bus_wdata[CR_DIS]) begin
                if (ser_busy) begin
                    st_d.pend_dis = st_q.en;
                end else begin
                    st_d.en       = 1'b0;
                    st_d.pend_dis = 1'b0;
                end
            end else if (bus_wdata[CR_EN]) begin
                st_d.en       = 1'b1;
                st_d.pend_dis = 1'b0;
                if (!st_q.en) st_d.tdre = 1'b1;
            end
        end

        // transmit side
        if (ser_load) st_d.tdre = 1'b1;
        if (tdr_wr) begin
            st_d.tdr_data = bus_wdata[WORD_W-1:0];
            st_d.tdr_pcs  = bus_wdata[PCS_LSB +: PCS_W];
            st_d.tdre     = 1'b0;
        end

        // read side effects first, so same-cycle events win
        if (rdr_rd) st_d.rdrf = 1'b0;
        if (sr_rd) begin
            st_d.ovres = 1'b0;
            st_d.modf  = 1'b0;
        end

        // receive side
        if (ser_done) begin
            st_d.rdr_data = ser_rx_data;
            st_d.rdr_pcs  = st_q.mr[MR_MSTR] ? ser_rx_pcs : '0;
            st_d.rdrf     = 1'b1;
            if (st_q.rdrf && !rdr_rd) st_d.ovres = 1'b1;
        end

        // mode fault
        if (modf_evt) begin
            st_d.modf     = 1'b1;
            st_d.en       = 1'b0;
            st_d.pend_dis = 1'b0;
        end

        if (!st_d.en) st_d.tdre = 1'b0;

        // configuration
        if (wr_acc && hit.mr) st_d.mr = bus_wdata & MR_KEEP;
        for (int k = 0; k < NUM_CS; k++) begin
            if (wr_acc && cs_hit[k]) csr_d[k] = bus_wdata & CSR_KEEP;
        end

        if (swrst) begin
            st_d  = '0;
            csr_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= '0;
            csr_q <= '0;
        end else begin
            st_q  <= st_d;
            csr_q <= csr_d;
        end
    end

    assign flags[ST_RXF] = st_q.rdrf;
    assign flags[ST_TXE] = st_q.tdre;
    assign flags[ST_MDF] = st_q.modf;
    assign flags[ST_OVR] = st_q.ovres;

    spi_rf_irq #(.N(N_FLAGS)) i_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .swrst  (swrst),
        .set_wr (wr_acc & hit.ier),
        .clr_wr (wr_acc & hit.idr),
        .wbits  (bus_wdata[N_FLAGS-1:0]),
        .flags  (flags),
        .mask   (imr),
        .irq    (irq)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (rd_acc) begin
            if (hit.mr) bus_rdata = st_q.mr;
            if (hit.rdr) begin
                bus_rdata[WORD_W-1:0]        = st_q.rdr_data;
                bus_rdata[PCS_LSB +: PCS_W]  = st_q.rdr_pcs;
            end
            if (hit.sr) begin
                bus_rdata[N_FLAGS-1:0] = flags;
                bus_rdata[ST_ENA]      = st_q.en;
            end
            if (hit.imr) bus_rdata[N_FLAGS-1:0] = imr;
            for (int k = 0; k < NUM_CS; k++) begin
                if (cs_hit[k]) bus_rdata = csr_q[k];
            end
        end
    end

    assign ser_tx_data = st_q.tdr_data;
    assign ser_tx_pcs  = st_q.tdr_pcs;
    assign ctl_enabled = st_q.en;
    assign cfg_mode    = st_q.mr;
    assign cfg_cs      = csr_q;

    // observation points for the bound checker
    logic chk_en, chk_tdre, chk_rdrf, chk_ovres, chk_modf;
    assign chk_en    = st_q.en;
    assign chk_tdre  = st_q.tdre;
    assign chk_rdrf  = st_q.rdrf;
    assign chk_ovres = st_q.ovres;
    assign chk_modf  = st_q.modf;
endmodule

// File: rtl/spi_rf_checker.sv
module spi_rf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cr_wr,
    input logic       tdr_wr,
    input logic       rdr_rd,
    input logic       swrst,
    input logic [1:0] cr_bits,
    input logic       ser_busy,
    input logic       ser_done,
    input logic       ser_load,
    input logic       en,
    input logic       tdre,
    input logic       rdrf,
    input logic       ovres,
    input logic       modf,
    input logic [3:0] imr,
    input logic       irq
);
    AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cr_wr && cr_bits == 2'b11 && !ser_busy |=> !en); // R2

    AST_DISABLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cr_wr && cr_bits[1] && ser_busy && en && !swrst |=> (en || modf)); // R3

    AST_TXE_LOW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !tdre); // R4

    AST_TXE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ser_load && !tdr_wr && !swrst |=> (tdre || !en)); // R4

    AST_RXF_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ser_done && !swrst |=> rdrf); // R5

    AST_OVR_ON_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        ser_done && rdrf && !rdr_rd && !swrst |=> ovres); // R6

    AST_MODF_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(modf) |-> !en); // R7

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        imr == 4'b0000 |-> !irq); // R9

    AST_IRQ_RXF: assert property (@(posedge clk) disable iff (!rst_n)
        rdrf && imr[0] |-> irq); // R9
endmodule

bind spi_regfile spi_rf_checker i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cr_wr    (cr_wr),
    .tdr_wr   (tdr_wr),
    .rdr_rd   (rdr_rd),
    .swrst    (swrst),
    .cr_bits  (bus_wdata[1:0]),
    .ser_busy (ser_busy),
    .ser_done (ser_done),
    .ser_load (ser_load),
    .en       (chk_en),
    .tdre     (chk_tdre),
    .rdrf     (chk_rdrf),
    .ovres    (chk_ovres),
    .modf     (chk_modf),
    .imr      (imr),
    .irq      (irq)
);

// File: tb/test_spi_regfile.sv
`timescale 1ns/1ps
module test_spi_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 0, bus_stb = 0, bus_wr = 0;
    logic [13:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        ss_n = 1'b1;
    logic        ser_ready = 0, ser_busy = 0, ser_done = 0;
    logic        ser_load;
    logic [15:0] ser_tx_data;
    logic [3:0]  ser_tx_pcs;
    logic [15:0] ser_rx_data = '0;
    logic [3:0]  ser_rx_pcs = '0;
    logic        ctl_enabled;
    logic [31:0] cfg_mode;
    logic [127:0] cfg_cs;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    spi_regfile i_spi_regfile (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_stb(bus_stb),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .ss_n(ss_n), .ser_ready(ser_ready),
        .ser_busy(ser_busy), .ser_load(ser_load), .ser_tx_data(ser_tx_data),
        .ser_tx_pcs(ser_tx_pcs), .ser_done(ser_done), .ser_rx_data(ser_rx_data),
        .ser_rx_pcs(ser_rx_pcs), .ctl_enabled(ctl_enabled), .cfg_mode(cfg_mode),
        .cfg_cs(cfg_cs)
    );

    // reference model for the random phase
    logic [3:0]  m_imr;
    logic        m_rxf, m_ovr;
    logic [31:0] m_rdr;

    function automatic logic [31:0] exp_sr(input logic rxf, ovr);
        return {28'b0, ovr, 1'b0, 1'b0, rxf};
    endfunction

    function automatic logic exp_irq(input logic [3:0] fl, input logic [3:0] msk);
        return |(fl & msk);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [13:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_stb = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_stb = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [13:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_stb = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0; bus_stb = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [13:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic done_pulse(input logic [15:0] d, input logic [3:0] p);
        @(negedge clk);
        ser_done = 1; ser_rx_data = d; ser_rx_pcs = p;
        @(negedge clk);
        ser_done = 0;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state and map
        rd_chk("R1 mode reset", 14'h04, 32'h0);
        rd_chk("R1 status reset", 14'h10, 32'h0);
        rd_chk("R1 mask reset", 14'h1C, 32'h0);
        rd_chk("R1 csr3 reset", 14'h3C, 32'h0);
        rd_chk("R1 rdr reset", 14'h08, 32'h0);
        chk("R1 irq reset", {31'b0, irq}, 32'h0);

        // R10 masks, R1 aliasing and unmapped
        wr(14'h04, 32'hFFFF_FFFF);
        rd_chk("R10 mode mask", 14'h05, 32'hFF0F_009F);
        chk("R10 cfg_mode", cfg_mode, 32'hFF0F_009F);
        wr(14'h3B, 32'hFFFF_FFFF);
        rd_chk("R10 csr2 mask", 14'h38, 32'hFFFF_FFF3);
        chk("R10 cfg_cs word2", cfg_cs[95:64], 32'hFFFF_FFF3);
        rd_chk("R1 unmapped", 14'h20, 32'h0);
        rd_chk("R1 write-only tdr", 14'h0C, 32'h0);
        wr(14'h04, 32'h0);
        wr(14'h38, 32'h0);

        // R2 / R4 enable
        wr(14'h00, 32'h1);
        rd_chk("R2 R4 enable sets ENA and TXE", 14'h10, 32'h0001_0002);
        wr(14'h0C, 32'h000A_1234);
        rd_chk("R4 tdr write clears TXE", 14'h10, 32'h0001_0000);
        @(negedge clk);
        ser_ready = 1;
        #1;
        chk("R4 load offered", {31'b0, ser_load}, 32'h1);
        chk("R4 tx data", {12'b0, ser_tx_pcs, ser_tx_data}, 32'h000A_1234);
        @(negedge clk);
        ser_ready = 0;
        chk("R4 load taken", {31'b0, ser_load}, 32'h0);
        rd_chk("R4 TXE after load", 14'h10, 32'h0001_0002);

        // R3 deferred disable
        ser_busy = 1;
        wr(14'h00, 32'h2);
        rd_chk("R3 held while busy", 14'h10, 32'h0001_0002);
        ser_busy = 0;
        @(negedge clk);
        rd_chk("R3 off after busy", 14'h10, 32'h0);

        // R2 both bits
        wr(14'h00, 32'h1);
        wr(14'h00, 32'h3);
        rd_chk("R2 disable wins", 14'h10, 32'h0);

        // R5 / R6 receive path in master mode
        wr(14'h04, 32'h1);
        done_pulse(16'h5A5A, 4'h7);
        rd_chk("R5 RXF set", 14'h10, 32'h1);
        done_pulse(16'h00FF, 4'h3);
        rd_chk("R6 overrun", 14'h10, 32'h9);
        rd_chk("R5 rdr master", 14'h08, 32'h0003_00FF);
        rd_chk("R6 R5 flags cleared", 14'h10, 32'h0);
        wr(14'h04, 32'h0);
        done_pulse(16'h1111, 4'h7);
        rd_chk("R5 rdr slave", 14'h08, 32'h0000_1111);

        // R12 status read races overrun
        done_pulse(16'h2222, 4'h0);
        @(negedge clk);
        bus_sel = 1; bus_stb = 1; bus_wr = 0; bus_addr = 14'h10;
        ser_done = 1; ser_rx_data = 16'h3333;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 0; bus_stb = 0; ser_done = 0;
        chk("R12 racing read value", v, 32'h1);
        rd_chk("R12 overrun kept", 14'h10, 32'h9);
        rd_chk("R12 rdr newest", 14'h08, 32'h0000_3333);
        rd_chk("R12 cleared", 14'h10, 32'h0);

        // R8 / R9 mask and interrupt
        done_pulse(16'h4444, 4'h0);
        chk("R9 masked off", {31'b0, irq}, 32'h0);
        wr(14'h14, 32'h1);
        chk("R9 irq up", {31'b0, irq}, 32'h1);
        wr(14'h14, 32'h0);
        wr(14'h18, 32'h0);
        rd_chk("R8 zeros no effect", 14'h1C, 32'h1);
        wr(14'h18, 32'h1);
        chk("R9 irq down", {31'b0, irq}, 32'h0);
        wr(14'h14, 32'hFFFF_FFFF);
        rd_chk("R8 set all", 14'h1C, 32'hF);

        // R11 software reset
        wr(14'h04, 32'h9F);
        wr(14'h30, 32'h1234);
        wr(14'h00, 32'h1);
        wr(14'h00, 32'h80);
        rd_chk("R11 mode", 14'h04, 32'h0);
        rd_chk("R11 csr0", 14'h30, 32'h0);
        rd_chk("R11 mask", 14'h1C, 32'h0);
        rd_chk("R11 status", 14'h10, 32'h0);

        // R7 mode fault
        wr(14'h04, 32'h1);
        wr(14'h00, 32'h1);
        ss_n = 0;
        repeat (4) @(negedge clk);
        rd_chk("R7 fault disables", 14'h10, 32'h4);
        chk("R7 enabled pin", {31'b0, ctl_enabled}, 32'h0);
        rd_chk("R7 cleared by read", 14'h10, 32'h0);
        ss_n = 1;
        repeat (3) @(negedge clk);
        wr(14'h04, 32'h11);
        wr(14'h00, 32'h1);
        ss_n = 0;
        repeat (4) @(negedge clk);
        rd_chk("R7 detection off", 14'h10, 32'h0001_0002);
        ss_n = 1;
        wr(14'h00, 32'h2);

        // random mix: R5 R6 R8 R9
        wr(14'h00, 32'h80);
        m_imr = '0; m_rxf = 0; m_ovr = 0; m_rdr = '0;
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [31:0] r;
            op = int'($urandom_range(0, 4));
            r  = $urandom;
            case (op)
                0: begin wr(14'h14, r); m_imr = m_imr | r[3:0]; end
                1: begin wr(14'h18, r); m_imr = m_imr & ~r[3:0]; end
                2: begin
                    done_pulse(r[15:0], r[19:16]);
                    if (m_rxf) m_ovr = 1;
                    m_rxf = 1;
                    m_rdr = {16'b0, r[15:0]};
                end
                3: begin rd_chk("R5 random rdr", 14'h08, m_rdr); m_rxf = 0; end
                default: begin
                    rd_chk("R6 random status", 14'h10, exp_sr(m_rxf, m_ovr));
                    m_ovr = 0;
                end
            endcase
            chk("R9 random irq", {31'b0, irq},
                {31'b0, exp_irq({m_ovr, 1'b0, 1'b0, m_rxf}, m_imr)});
            if (op < 2) rd_chk("R8 random mask", 14'h1C, {28'b0, m_imr});
        end

        report();
    end
endmodule